// File: doc/BRIEF.md
# CAN Fault Confinement Error Counter Unit

This unit keeps the two fault-confinement counters of a CAN node, one for receive errors and one for transmit errors. A protocol sequencer elsewhere in the controller detects errors and successful frames. It tells this unit what happened through one-cycle, two-bit command codes, one code per counter per cycle. The unit turns those commands into counter updates and reports the node's confinement state. It also drives a flag that tells the sequencer which kind of error flag to send.

The confinement state comes straight from the counter values, so no separate state register can drift away from the counts. Once the transmit counter has gone past its bus-off limit, the counters are frozen. The only way back is a recovery request followed by a fixed number of idle-bus sequences. An idle-bus sequence is one run of 11 recessive bits, which the sequencer reports as a pulse. After the last of these sequences both counters return to zero.

Top module: `can_fc_unit`

## Requirements
- R1: After reset both counters read 0, the state is error active (code 2'b00) and the passive-flag output is 0.
- R2: A command code applies to its counter on the clock edge where it is present: 2'b01 adds 1, 2'b10 adds 8, 2'b11 decrements, and 2'b00 leaves the counter unchanged.
- R3: A decrement command on a counter that holds 0 leaves it at 0.
- R4: The receive counter saturates at 255 and never wraps around to a small value.
- R5: A decrement command on the receive counter while it holds more than 127 loads it with 119.
- R6: The state is error passive (code 2'b01) whenever either counter is 128 or more and the transmit counter is 255 or less. The passive-flag output is 1 exactly in this state.
- R7: The state is bus-off (code 2'b10) whenever the transmit counter exceeds 255. While in bus-off, all commands on both counters are ignored and both counters keep their values.
- R8: In bus-off, a recovery request followed by 128 idle-sequence pulses clears both counters and returns the state to error active. The clear happens on the edge of the 128th pulse. Idle pulses that arrive before the request are not counted.
- R9: A recovery request made while the node is not bus-off has no effect, and later idle pulses do not change the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_cmd_i | input | 2 | Receive counter command code |
| tx_cmd_i | input | 2 | Transmit counter command code |
| recov_req_i | input | 1 | Request to leave bus-off |
| idle_seq_i | input | 1 | Pulse: 11 consecutive recessive bits observed |
| rec_o | output | 8 | Receive error counter |
| tec_o | output | 9 | Transmit error counter |
| state_o | output | 2 | Confinement state: 00 active, 01 passive, 10 bus-off |
| passive_flag_o | output | 1 | Send passive error flags |

## Verification
The bench checks the threshold edges by stopping one step short of 128 and of 256 and then taking the final step. A design with an off-by-one compare would change state one step early or one step late. It pushes the receive counter past 255, so a wrapping counter would show a small value. It also decrements from above 127 and checks for the reload value 119 rather than 254. In bus-off it sends idle pulses before the recovery request and then stops at 127 pulses after it. A design that counted the early pulses, or that cleared one pulse early, would leave bus-off too soon. A recovery request made while the node is only passive is also checked, to confirm it does not arm the recovery.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  typedef enum logic [1:0] {
    CMD_NONE    = 2'b00,
    CMD_INC_ONE = 2'b01,
    CMD_INC_BIG = 2'b10,
    CMD_DEC     = 2'b11
  } fc_cmd_e;

  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'b00,
    ST_PASSIVE = 2'b01,
    ST_BUSOFF  = 2'b10
  } fc_state_e;
endpackage

// File: rtl/can_fc_counter.sv
module can_fc_counter
  import can_fc_pkg::*;
#(
  parameter int W            = 8,
  parameter int BIG_STEP     = 8,
  parameter bit RELOAD_EN    = 1'b0,
  parameter int RELOAD_ABOVE = 127,
  parameter int RELOAD_VAL   = 119
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   cmd_i,
  input  logic         hold_i,
  input  logic         clear_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] MAXV     = {W{1'b1}};
  localparam logic [W-1:0] BIG_LIM  = MAXV - W'(BIG_STEP);
  localparam logic [W-1:0] RL_ABOVE = W'(RELOAD_ABOVE);
  localparam logic [W-1:0] RL_VAL   = W'(RELOAD_VAL);

  fc_cmd_e      cmd;
  logic [W-1:0] q_q, q_nx;
  logic         en;

  assign cmd = fc_cmd_e'(cmd_i);

  always_comb begin
    q_nx = q_q;
    if (clear_i) begin
      q_nx = '0;
    end else if (!hold_i) begin
      case (cmd)
        CMD_INC_ONE: q_nx = (q_q == MAXV) ? MAXV : q_q + 1'b1;
        CMD_INC_BIG: q_nx = (q_q > BIG_LIM) ? MAXV : q_q + W'(BIG_STEP);
        CMD_DEC: begin
          if (RELOAD_EN && (q_q > RL_ABOVE)) q_nx = RL_VAL;
          else if (q_q != '0)                q_nx = q_q - 1'b1;
        end
        default: q_nx = q_q;
      endcase
    end
  end

  assign en = clear_i | (!hold_i && (cmd != CMD_NONE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_q <= '0;
    else if (en) q_q <= q_nx;
  end

  assign q_o = q_q;

  assert_inc_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_INC_ONE && !hold_i && !clear_i && q_q != MAXV) |=> (q_q == $past(q_q) + 1'b1));

  assert_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_DEC && !hold_i && !clear_i && q_q == '0) |=> (q_q == '0));

  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != CMD_DEC && !clear_i && q_q == MAXV) |=> (q_q == MAXV));

  assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && !clear_i) |=> $stable(q_q));
endmodule

// File: rtl/can_fc_recovery.sv
module can_fc_recovery #(
  parameter int RECOV_COUNT = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busoff_i,
  input  logic req_i,
  input  logic idle_i,
  output logic clear_o
);
  localparam int CW = (RECOV_COUNT > 1) ? $clog2(RECOV_COUNT) : 1;
  localparam logic [CW-1:0] LAST = CW'(RECOV_COUNT - 1);

  logic          armed_q, armed_nx;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic          cnt_en;

  assign clear_o = armed_q && idle_i && (cnt_q == LAST);

  always_comb begin
    armed_nx = armed_q;
    if (!busoff_i || clear_o) armed_nx = 1'b0;
    else if (req_i)           armed_nx = 1'b1;
  end

  always_comb begin
    cnt_nx = cnt_q;
    if (!armed_q || clear_o) cnt_nx = '0;
    else if (idle_i)         cnt_nx = cnt_q + 1'b1;
  end

  assign cnt_en = !armed_q || idle_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nx;
  end

  assert_clear_only_busoff_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_o |-> busoff_i);

  assert_not_armed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busoff_i |=> !armed_q);
endmodule

// File: rtl/can_fc_unit.sv
module can_fc_unit
  import can_fc_pkg::*;
#(
  parameter int REC_W       = 8,
  parameter int TEC_W       = 9,
  parameter int BIG_STEP    = 8,
  parameter int PASSIVE_LIM = 128,
  parameter int BUSOFF_LIM  = 255,
  parameter int RX_RELOAD   = 119,
  parameter int RECOV_COUNT = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       rx_cmd_i,
  input  logic [1:0]       tx_cmd_i,
  input  logic             recov_req_i,
  input  logic             idle_seq_i,
  output logic [REC_W-1:0] rec_o,
  output logic [TEC_W-1:0] tec_o,
  output logic [1:0]       state_o,
  output logic             passive_flag_o
);
  localparam logic [REC_W-1:0] REC_PASS = REC_W'(PASSIVE_LIM);
  localparam logic [TEC_W-1:0] TEC_PASS = TEC_W'(PASSIVE_LIM);
  localparam logic [TEC_W-1:0] TEC_OFF  = TEC_W'(BUSOFF_LIM);

  logic [REC_W-1:0] rec;
  logic [TEC_W-1:0] tec;
  logic             busoff, passive, recov_clear;
  fc_state_e        state;

  can_fc_counter #(
    .W(REC_W), .BIG_STEP(BIG_STEP), .RELOAD_EN(1'b1),
    .RELOAD_ABOVE(PASSIVE_LIM - 1), .RELOAD_VAL(RX_RELOAD)
  ) u_rec (
    .clk(clk), .rst_n(rst_n), .cmd_i(rx_cmd_i),
    .hold_i(busoff), .clear_i(recov_clear), .q_o(rec)
  );

  can_fc_counter #(
    .W(TEC_W), .BIG_STEP(BIG_STEP), .RELOAD_EN(1'b0),
    .RELOAD_ABOVE(0), .RELOAD_VAL(0)
  ) u_tec (
    .clk(clk), .rst_n(rst_n), .cmd_i(tx_cmd_i),
    .hold_i(busoff), .clear_i(recov_clear), .q_o(tec)
  );

  can_fc_recovery #(.RECOV_COUNT(RECOV_COUNT)) u_recov (
    .clk(clk), .rst_n(rst_n), .busoff_i(busoff),
    .req_i(recov_req_i), .idle_i(idle_seq_i), .clear_o(recov_clear)
  );

  assign busoff  = tec > TEC_OFF;
  assign passive = (rec >= REC_PASS) || (tec >= TEC_PASS);

  always_comb begin
    if (busoff)       state = ST_BUSOFF;
    else if (passive) state = ST_PASSIVE;
    else              state = ST_ACTIVE;
  end

  assign rec_o          = rec;
  assign tec_o          = tec;
  assign state_o        = state;
  assign passive_flag_o = (state == ST_PASSIVE);

  assert_passive_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_PASSIVE) |-> (rec_o >= REC_PASS || tec_o >= TEC_PASS));

  assert_exit_busoff_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_BUSOFF && !recov_clear) |=> (state_o == ST_BUSOFF));

  assert_rx_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cmd_i == 2'b11 && !busoff && !recov_clear && rec_o > REC_PASS - 1'b1)
      |=> (rec_o == REC_W'(RX_RELOAD)));
endmodule

// File: tb/can_fc_unit_bench.sv
module can_fc_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] rx_cmd, tx_cmd;
  logic       req, idle;
  logic [7:0] rec;
  logic [8:0] tec;
  logic [1:0] state;
  logic       pflag;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  can_fc_unit u_can_fc_unit (
    .clk(clk), .rst_n(rst_n), .rx_cmd_i(rx_cmd), .tx_cmd_i(tx_cmd),
    .recov_req_i(req), .idle_seq_i(idle), .rec_o(rec), .tec_o(tec),
    .state_o(state), .passive_flag_o(pflag)
  );

  // {rx_cmd, tx_cmd, exp_rec, exp_tec, exp_state} applied from reset (R2)
  localparam int NV = 6;
  localparam logic [22:0] VEC [NV] = '{
    {2'b10, 2'b01, 8'd8, 9'd1,  2'b00},
    {2'b01, 2'b10, 8'd9, 9'd9,  2'b00},
    {2'b11, 2'b11, 8'd8, 9'd8,  2'b00},
    {2'b00, 2'b00, 8'd8, 9'd8,  2'b00},
    {2'b11, 2'b00, 8'd7, 9'd8,  2'b00},
    {2'b00, 2'b10, 8'd7, 9'd16, 2'b00}
  };

  task automatic check(input string req_tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [1:0] r, input logic [1:0] t,
                     input logic q, input logic i);
    rx_cmd = r; tx_cmd = t; req = q; idle = i;
    @(posedge clk); #1;
    rx_cmd = 2'b00; tx_cmd = 2'b00; req = 1'b0; idle = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    rx_cmd = 2'b00; tx_cmd = 2'b00; req = 1'b0; idle = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    check("R1 rec", rec, 0);
    check("R1 tec", tec, 0);
    check("R1 state", state, 0);
    check("R1 flag", pflag, 0);

    for (int k = 0; k < NV; k++) begin
      cyc(VEC[k][22:21], VEC[k][20:19], 1'b0, 1'b0);
      check("R2 rec", rec, VEC[k][18:11]);
      check("R2 tec", tec, VEC[k][10:2]);
      check("R2 state", state, VEC[k][1:0]);
    end

    // R3: decrement at zero
    do_reset();
    cyc(2'b11, 2'b11, 1'b0, 1'b0);
    check("R3 rec", rec, 0);
    check("R3 tec", tec, 0);

    // R6: receive counter threshold
    for (int k = 0; k < 15; k++) cyc(2'b10, 2'b00, 1'b0, 1'b0);
    check("R6 rec120", rec, 120);
    check("R6 active at 120", state, 0);
    cyc(2'b10, 2'b00, 1'b0, 1'b0);
    check("R6 passive at 128", state, 1);
    check("R6 flag", pflag, 1);

    // R4: saturation
    for (int k = 0; k < 17; k++) cyc(2'b10, 2'b00, 1'b0, 1'b0);
    check("R4 sat", rec, 255);
    cyc(2'b01, 2'b00, 1'b0, 1'b0);
    check("R4 sat inc1", rec, 255);

    // R5: reload on decrement above 127
    cyc(2'b11, 2'b00, 1'b0, 1'b0);
    check("R5 reload", rec, 119);
    check("R5 active", state, 0);

    // R9: request outside bus-off, then idle pulses
    for (int k = 0; k < 16; k++) cyc(2'b00, 2'b10, 1'b0, 1'b0);
    check("R6 tec passive", state, 1);
    cyc(2'b00, 2'b00, 1'b1, 1'b0);
    for (int k = 0; k < 130; k++) cyc(2'b00, 2'b00, 1'b0, 1'b1);
    check("R9 tec", tec, 128);
    check("R9 rec", rec, 119);

    // R7: bus-off threshold
    for (int k = 0; k < 15; k++) cyc(2'b00, 2'b10, 1'b0, 1'b0);
    check("R7 tec248", tec, 248);
    check("R7 still passive", state, 1);
    cyc(2'b00, 2'b10, 1'b0, 1'b0);
    check("R7 busoff", state, 2);
    check("R7 flag", pflag, 0);
    cyc(2'b01, 2'b11, 1'b0, 1'b0);
    cyc(2'b11, 2'b10, 1'b0, 1'b0);
    check("R7 rec frozen", rec, 119);
    check("R7 tec frozen", tec, 256);

    // R8: recovery sequence
    for (int k = 0; k < 5; k++) cyc(2'b00, 2'b00, 1'b0, 1'b1);
    check("R8 early idle", state, 2);
    cyc(2'b00, 2'b00, 1'b1, 1'b0);
    for (int k = 0; k < 127; k++) cyc(2'b00, 2'b00, 1'b0, 1'b1);
    check("R8 after 127", state, 2);
    check("R8 tec held", tec, 256);
    cyc(2'b00, 2'b00, 1'b0, 1'b1);
    check("R8 state", state, 0);
    check("R8 rec", rec, 0);
    check("R8 tec", tec, 0);

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule